// File: doc/BRIEF.md
# Serial-Loaded Quad Converter Code Bank

This block is the digital front end of a four-channel 8-bit converter. Software or a host controller sends a short control word bit by bit on a serial clock and data pair. The block keeps, for every channel, a staged copy and a live copy of an 8-bit code and a range flag. A frame strobe marks when serial data is valid. When the frame strobe drops, the captured word goes into the staged copy of the channel it names.

A second strobe, active low, decides when staged values reach the live outputs. If it is held low, a completed word goes straight to its channel's outputs. If it is held high, words only collect in the staged copies, and a later falling edge of this strobe moves all four staged copies to the outputs in the same cycle. All four serial-side inputs are brought into the system clock domain through synchronizers, and every action is decided from edges seen in that domain.

Top module: `quad_dac_regbank`

## Requirements
- R1: After reset, all four live codes, all four live range flags and all staged copies are zero.
- R2: A bit is taken from `serData` only on a falling edge of `serClk` while `frameN` is high. Falling edges of `serClk` while `frameN` is low, and all rising edges, leave the captured word unchanged.
- R3: Bits arrive most significant first. The captured word is the last 11 bits taken before `frameN` falls: two channel-select bits (high first), then the range flag, then code bit 7 down to code bit 0. Any earlier bits, such as those in a 16-clock frame, are discarded.
- R4: Channel select 00 targets channel 0 (`codeOut[7:0]`, `rangeOut[0]`), 01 targets channel 1, 10 targets channel 2 and 11 targets channel 3 (`codeOut[31:24]`, `rangeOut[3]`).
- R5: A falling edge of `frameN` while `commitN` is low writes the word to both the staged and the live copy of the selected channel. The other three channels' outputs do not change.
- R6: A falling edge of `frameN` while `commitN` is high writes only the staged copy of the selected channel. No output changes.
- R7: A falling edge of `commitN` copies every staged copy to its live outputs in the same cycle. Outputs change at no other time except under R5.
- R8: When a falling edge of `frameN` and a falling edge of `commitN` are seen in the same cycle, the selected channel's outputs take the new word. The other channels take their staged copies.
- R9: Each channel's range flag (0 for unity full scale, 1 for doubled full scale) is loaded from the same word and at the same moment as its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial bit clock; a bit is taken on its falling edge |
| serData | input | 1 | Serial data bit |
| frameN | input | 1 | High while shifting; a falling edge latches the word |
| commitN | input | 1 | Low level makes latches reach the outputs directly; a falling edge commits all staged copies |
| codeOut | output | 32 | Live 8-bit codes, channel 0 in the lowest byte |
| rangeOut | output | 4 | Live range flags, bit n for channel n |

## Verification
The word latch and the global commit can land in the same system cycle. In that cycle the selected channel has two possible sources, the new word and its old staged copy. The bench provokes this by first staging values in several channels with `commitN` high. It then lowers `frameN` and `commitN` at the same instant, so both pass through identical synchronizers and arrive together. The result is judged against a model: the selected channel must show the fresh word, and the other three must show their staged values.

// File: rtl/dac_bank_pkg.sv
`timescale 1ns/1ps
package dac_bank_pkg;

  // Strobes handed from the control path to the datapath, one cycle wide.
  typedef struct packed {
    logic shiftBit;   // take one serial bit into the capture register
    logic latchWord;  // frame strobe fell: capture register -> staged copy
    logic directOut;  // latch with commit level low: also drive live copy
    logic commitAll;  // commit strobe fell: every staged copy -> live copy
  } ctrlStrobes_t;

endpackage

// File: rtl/dac_sync.sv
`timescale 1ns/1ps
module dac_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= IDLE_VAL;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= IDLE_VAL;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/dac_ctrl.sv
`timescale 1ns/1ps
module dac_ctrl
  import dac_bank_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkSync,
  input  logic         frameSync,
  input  logic         commitSync,
  output ctrlStrobes_t strobes
);

  logic sclkPrev, framePrev, commitPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev   <= 1'b1;
      framePrev  <= 1'b1;
      commitPrev <= 1'b1;
    end else begin
      sclkPrev   <= sclkSync;
      framePrev  <= frameSync;
      commitPrev <= commitSync;
    end
  end

  logic sclkFall, frameFall, commitFall;

  always_comb begin
    sclkFall   = sclkPrev & ~sclkSync;
    frameFall  = framePrev & ~frameSync;
    commitFall = commitPrev & ~commitSync;

    strobes.shiftBit  = sclkFall & frameSync;
    strobes.latchWord = frameFall;
    strobes.directOut = frameFall & ~commitSync;
    strobes.commitAll = commitFall;
  end

endmodule

// File: rtl/dac_datapath.sv
`timescale 1ns/1ps
module dac_datapath
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic                     dataBit,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        rangeOut
);

  localparam int WORD_W  = ADDR_W + 1 + CODE_W;
  localparam int ENTRY_W = CODE_W + 1;
  localparam int RANGE_POS = CODE_W;

  logic [WORD_W-1:0] captureReg;
  logic [ADDR_W-1:0] selAddr;
  logic [ENTRY_W-1:0] newEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 captureReg <= '0;
    else if (strobes.shiftBit) captureReg <= {captureReg[WORD_W-2:0], dataBit};
  end

  assign selAddr  = captureReg[WORD_W-1 -: ADDR_W];
  assign newEntry = captureReg[ENTRY_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [ENTRY_W-1:0] stagedEntry;
    logic [ENTRY_W-1:0] liveEntry;
    logic               hit;

    assign hit = (selAddr == ADDR_W'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           stagedEntry <= '0;
      else if (strobes.latchWord && hit)   stagedEntry <= newEntry;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveEntry <= '0;
      end else if (strobes.directOut && hit) begin
        liveEntry <= newEntry;
      end else if (strobes.commitAll) begin
        liveEntry <= stagedEntry;
      end
    end

    assign codeOut[ch*CODE_W +: CODE_W] = liveEntry[CODE_W-1:0];
    assign rangeOut[ch]                 = liveEntry[RANGE_POS];
  end

endmodule

// File: rtl/quad_dac_regbank.sv
`timescale 1ns/1ps
module quad_dac_regbank
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serData,
  input  logic                     frameN,
  input  logic                     commitN,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        rangeOut
);

  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // Order: serClk, serData, frameN, commitN; strobes and clock idle high.
  logic [3:0] rawIn, syncIn;
  assign rawIn = {serClk, serData, frameN, commitN};

  dac_sync #(
    .WIDTH(4),
    .STAGES(SYNC_STAGES),
    .IDLE_VAL(4'b1011)
  ) uSync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn(rawIn),
    .syncOut(syncIn)
  );

  ctrlStrobes_t strobes;

  dac_ctrl uCtrl (
    .clk(clk),
    .rstN(rstN),
    .sclkSync(syncIn[3]),
    .frameSync(syncIn[1]),
    .commitSync(syncIn[0]),
    .strobes(strobes)
  );

  dac_datapath #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W)
  ) uPath (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .dataBit(syncIn[2]),
    .codeOut(codeOut),
    .rangeOut(rangeOut)
  );

  logic evtLatch, evtDirect, evtCommit;
  assign evtLatch  = strobes.latchWord;
  assign evtDirect = strobes.directOut;
  assign evtCommit = strobes.commitAll;

endmodule

// File: rtl/dac_regbank_checker.sv
`timescale 1ns/1ps
module dac_regbank_checker #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_CH*CODE_W-1:0] codeOut,
  input logic [NUM_CH-1:0]        rangeOut,
  input logic                     evtLatch,
  input logic                     evtDirect,
  input logic                     evtCommit
);

  logic [NUM_CH*CODE_W-1:0] prevCode;
  logic [NUM_CH-1:0]        prevRange;
  logic [NUM_CH-1:0]        changedMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode  <= '0;
      prevRange <= '0;
    end else begin
      prevCode  <= codeOut;
      prevRange <= rangeOut;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      changedMask[c] = (codeOut[c*CODE_W +: CODE_W] != prevCode[c*CODE_W +: CODE_W]) ||
                       (rangeOut[c] != prevRange[c]);
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (codeOut == '0) && (rangeOut == '0)); // R1

  AST_DIRECT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (evtDirect && !evtCommit) |=> $onehot0(changedMask)); // R5

  AST_STAGED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (evtLatch && !evtDirect && !evtCommit) |=> ($stable(codeOut) && $stable(rangeOut))); // R6

  AST_NO_EVENT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!evtLatch && !evtCommit) |=> ($stable(codeOut) && $stable(rangeOut))); // R7

endmodule

bind quad_dac_regbank dac_regbank_checker #(
  .NUM_CH(NUM_CH),
  .CODE_W(CODE_W)
) uChecker (
  .clk(clk),
  .rstN(rstN),
  .codeOut(codeOut),
  .rangeOut(rangeOut),
  .evtLatch(evtLatch),
  .evtDirect(evtDirect),
  .evtCommit(evtCommit)
);

// File: tb/tb_quad_dac_regbank.sv
`timescale 1ns/1ps
module tb_quad_dac_regbank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b1;
  logic        serData = 1'b0;
  logic        frameN = 1'b1;
  logic        commitN = 1'b1;
  logic [31:0] codeOut;
  logic [3:0]  rangeOut;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [8:0] stagedM [4];
  logic [8:0] liveM   [4];

  always #10 clk = ~clk;

  quad_dac_regbank dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .frameN(frameN), .commitN(commitN), .codeOut(codeOut), .rangeOut(rangeOut)
  );

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [35:0] expectedOut();
    logic [35:0] v;
    for (int c = 0; c < 4; c++) begin
      v[c*8 +: 8] = liveM[c][7:0];
      v[32 + c]   = liveM[c][8];
    end
    return v;
  endfunction

  task automatic checkAll(input string tag);
    logic [35:0] exp, act;
    exp = expectedOut();
    act = {rangeOut, codeOut};
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual range=%b code=%h expected range=%b code=%h",
               tag, act[35:32], act[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic sendBits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      idle(4);
      serClk = 1'b0;
      idle(4);
      serClk = 1'b1;
      idle(4);
    end
  endtask

  // Word on the wire: {select[1:0], range, code[7:0]}, MSB first (R3).
  task automatic shiftWord(input logic [1:0] sel, input logic rng, input logic [7:0] code,
                           input int padN, input logic [4:0] pad);
    if (padN > 0) sendBits({11'b0, pad}, padN);
    sendBits({5'b0, sel, rng, code}, 11);
  endtask

  task automatic latchPulse(input logic [1:0] sel, input logic rng, input logic [7:0] code);
    frameN = 1'b0;
    stagedM[sel] = {rng, code};
    if (!commitN) liveM[sel] = {rng, code};
    idle(6);
    frameN = 1'b1;
    idle(6);
  endtask

  task automatic setCommit(input logic v);
    if (!v && commitN)
      for (int c = 0; c < 4; c++) liveM[c] = stagedM[c];
    commitN = v;
    idle(6);
  endtask

  task automatic loadWord(input logic [1:0] sel, input logic rng, input logic [7:0] code,
                          input int padN, input logic [4:0] pad);
    shiftWord(sel, rng, code, padN, pad);
    latchPulse(sel, rng, code);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      stagedM[c] = '0;
      liveM[c] = '0;
    end
    idle(3);
    checkAll("R1 outputs held at zero during reset");
    rstN = 1'b1;
    idle(4);
    checkAll("R1 reset state zero");

    // R4 / R5: direct writes to each channel, commit level low.
    setCommit(1'b0);
    checkAll("R7 commit of zero staged copies");
    loadWord(2'b00, 1'b0, 8'h11, 0, 5'd0);
    checkAll("R4 R5 select 00 to channel 0");
    loadWord(2'b01, 1'b1, 8'h22, 0, 5'd0);
    checkAll("R4 R5 R9 select 01 to channel 1 with range");
    loadWord(2'b10, 1'b0, 8'hA5, 0, 5'd0);
    checkAll("R4 R5 select 10 to channel 2");
    loadWord(2'b11, 1'b1, 8'hFF, 0, 5'd0);
    checkAll("R4 R5 R9 select 11 to channel 3");

    // R3: 16-clock frame, leading five bits discarded.
    loadWord(2'b01, 1'b0, 8'h3C, 5, 5'b11111);
    checkAll("R3 sixteen-bit frame keeps last eleven");

    // R2: serial clocks while frame is low are ignored.
    shiftWord(2'b10, 1'b1, 8'h00, 0, 5'd0);
    frameN = 1'b0;
    stagedM[2] = 9'h100;
    liveM[2] = 9'h100;
    idle(6);
    serData = 1'b1;
    for (int k = 0; k < 3; k++) begin
      serClk = 1'b0; idle(4); serClk = 1'b1; idle(4);
    end
    frameN = 1'b1;
    idle(6);
    checkAll("R2 first latch of word");
    latchPulse(2'b10, 1'b1, 8'h00);
    checkAll("R2 clocks during frame low did not shift");

    // R6 / R7: stage three channels, then commit together.
    setCommit(1'b1);
    loadWord(2'b00, 1'b1, 8'h5A, 0, 5'd0);
    checkAll("R6 staged write leaves outputs");
    loadWord(2'b11, 1'b0, 8'h07, 0, 5'd0);
    loadWord(2'b01, 1'b1, 8'hC3, 0, 5'd0);
    checkAll("R6 three staged writes leave outputs");
    setCommit(1'b0);
    checkAll("R7 commit moves all staged copies");
    setCommit(1'b1);

    // R8: latch and commit falling together.
    loadWord(2'b10, 1'b0, 8'h99, 0, 5'd0);
    loadWord(2'b11, 1'b1, 8'h44, 0, 5'd0);
    shiftWord(2'b00, 1'b0, 8'hE1, 0, 5'd0);
    frameN = 1'b0;
    commitN = 1'b0;
    for (int c = 0; c < 4; c++) liveM[c] = stagedM[c];
    stagedM[0] = 9'h0E1;
    liveM[0] = 9'h0E1;
    idle(6);
    frameN = 1'b1;
    idle(6);
    checkAll("R8 coincident latch and commit");
    setCommit(1'b1);

    // Random mix with fixed seed.
    void'($urandom(32'd20240611));
    for (int it = 0; it < 40; it++) begin
      logic [1:0] sel;
      logic rng;
      logic [7:0] code;
      int mode, padN;
      logic [4:0] pad;
      sel = 2'($urandom());
      rng = 1'($urandom());
      code = 8'($urandom());
      mode = int'($urandom() % 3);
      padN = int'($urandom() % 6);
      pad = 5'($urandom());
      if (mode == 0) setCommit(1'b0);
      else setCommit(1'b1);
      loadWord(sel, rng, code, padN, pad);
      if (mode == 0) checkAll("R5 R3 random direct write");
      else checkAll("R6 R3 random staged write");
      if (mode == 2) begin
        setCommit(1'b0);
        checkAll("R7 R9 random commit");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule